// File: doc/BRIEF.md
# Multicycle Program Counter Update Unit

This block keeps the program counter of a multicycle processor and a separate branch-target register, and picks the next program counter value. The controller drives plain strobes, one per cycle. An unconditional write strobe loads the counter. A conditional write strobe loads it only when the ALU reports a zero result. A target strobe captures the ALU result into the target register. A two-bit source select decides what the counter loads.

There are three sources. The first is the ALU result, which is the incremented counter during instruction fetch. The second is the previously captured branch target. The third is an absolute jump address. The jump address keeps the top bits of the current counter, places the 26-bit instruction jump field below them, and ends in two zero bits. Every pin is a plain control or data signal. Nothing flows as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pcu_top`

## Requirements
- R1: A synchronous active-high reset clears both the program counter and the target register to zero at the next rising clock edge.
- R2: When the counter write is enabled and the source select is 00, the counter loads the ALU result at the clock edge.
- R3: When the counter write is enabled and the source select is 01, the counter loads the value that the target register held before that clock edge.
- R4: When the counter write is enabled and the source select is 10, the counter loads {current counter bits 31..28, jump field bits 25..0, 2'b00}.
- R5: Source select 11 behaves exactly like 00: the counter loads the ALU result.
- R6: The target register loads the ALU result when the target strobe is high, and holds its value otherwise.
- R7: With the unconditional strobe low, the conditional strobe writes the counter only while the zero flag is 1. With the zero flag at 0, the counter holds.
- R8: The unconditional strobe writes the counter whatever the value of the zero flag.
- R9: With both write strobes low, the counter holds its value whatever the source select and data inputs are.
- R10: If the target strobe and a counter write with select 01 occur in the same cycle, the counter receives the old target and the target register receives the new ALU result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alu_res | input | 32 | ALU result |
| alu_zero | input | 1 | ALU zero flag |
| jump_field | input | 26 | Jump field from the instruction |
| pc_wr | input | 1 | Unconditional counter write strobe |
| pc_wr_cond | input | 1 | Counter write strobe gated by the zero flag |
| tgt_wr | input | 1 | Target register load strobe |
| pc_src | input | 2 | Next-counter source select (00 ALU, 01 target, 10 jump, 11 ALU) |
| pc_q | output | 32 | Current program counter |
| tgt_q | output | 32 | Stored branch target |

## Verification
The hardest case to reach is when the same edge both reads the target register and overwrites it. A second hard case is a jump whose upper address bits must come from a counter value set by an earlier, unrelated load. To reach these, the bench sweeps every combination of the three strobes, the zero flag and the four select codes. It repeats the sweep over several rounds of pseudo-random ALU results and jump fields. This leaves the counter's upper bits arbitrary before each jump, and it makes the target-overlap case appear in every round.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ = 2'b00,
    SRC_BR  = 2'b01,
    SRC_JMP = 2'b10,
    SRC_ALT = 2'b11
  } pc_src_e;
endpackage

// File: rtl/pcu_wen.sv
// Counter write enable: unconditional strobe, or conditional strobe with zero.
module pcu_wen (
  input  logic pc_wr,
  input  logic pc_wr_cond,
  input  logic alu_zero,
  output logic wen
);
  always_comb wen = pc_wr | (pc_wr_cond & alu_zero);
endmodule

// File: rtl/pcu_next.sv
// Next-counter selection among ALU result, stored target and jump address.
module pcu_next
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int JF_W   = 26,
  parameter int ALIGN  = 2,
  localparam int HI_W  = ADDR_W - JF_W - ALIGN
) (
  input  logic [1:0]        src,
  input  logic [ADDR_W-1:0] alu_res,
  input  logic [ADDR_W-1:0] tgt,
  input  logic [HI_W-1:0]   pc_hi,
  input  logic [JF_W-1:0]   jf,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] jmp_addr;

  always_comb jmp_addr = {pc_hi, jf, {ALIGN{1'b0}}};

  always_comb begin
    case (pc_src_e'(src))
      SRC_BR:  nxt = tgt;
      SRC_JMP: nxt = jmp_addr;
      default: nxt = alu_res;   // SRC_SEQ and SRC_ALT
    endcase
  end
endmodule

// File: rtl/pcu_reg.sv
// Enabled register with synchronous clear.
module pcu_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/pcu_top.sv
module pcu_top #(
  parameter int ADDR_W = 32,
  parameter int JF_W   = 26,
  parameter int ALIGN  = 2,
  localparam int HI_W  = ADDR_W - JF_W - ALIGN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] alu_res,
  input  logic              alu_zero,
  input  logic [JF_W-1:0]   jump_field,
  input  logic              pc_wr,
  input  logic              pc_wr_cond,
  input  logic              tgt_wr,
  input  logic [1:0]        pc_src,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] tgt_q
);
  logic              pc_en;
  logic [ADDR_W-1:0] pc_nxt;

  pcu_wen u_wen (
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .alu_zero   (alu_zero),
    .wen        (pc_en)
  );

  pcu_next #(.ADDR_W(ADDR_W), .JF_W(JF_W), .ALIGN(ALIGN)) u_next (
    .src     (pc_src),
    .alu_res (alu_res),
    .tgt     (tgt_q),
    .pc_hi   (pc_q[ADDR_W-1 -: HI_W]),
    .jf      (jump_field),
    .nxt     (pc_nxt)
  );

  pcu_reg #(.W(ADDR_W)) u_pc (
    .clk (clk), .rst (rst), .en (pc_en), .d (pc_nxt), .q (pc_q)
  );

  pcu_reg #(.W(ADDR_W)) u_tgt (
    .clk (clk), .rst (rst), .en (tgt_wr), .d (alu_res), .q (tgt_q)
  );
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
  parameter int ADDR_W = 32,
  parameter int JF_W   = 26,
  parameter int ALIGN  = 2,
  localparam int HI_W  = ADDR_W - JF_W - ALIGN
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] alu_res,
  input logic              alu_zero,
  input logic [JF_W-1:0]   jump_field,
  input logic              pc_wr,
  input logic              pc_wr_cond,
  input logic              tgt_wr,
  input logic [1:0]        pc_src,
  input logic [ADDR_W-1:0] pc_q,
  input logic [ADDR_W-1:0] tgt_q
);
  logic go;
  always_comb go = pc_wr | (pc_wr_cond & alu_zero);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && tgt_q == '0));

  p_seq_r2: assert property (@(posedge clk) disable iff (rst)
    (go && pc_src == 2'b00) |=> pc_q == $past(alu_res));

  p_branch_r3: assert property (@(posedge clk) disable iff (rst)
    (go && pc_src == 2'b01) |=> pc_q == $past(tgt_q));

  p_jump_r4: assert property (@(posedge clk) disable iff (rst)
    (go && pc_src == 2'b10) |=>
      pc_q == {$past(pc_q[ADDR_W-1 -: HI_W]), $past(jump_field), {ALIGN{1'b0}}});

  p_alt_r5: assert property (@(posedge clk) disable iff (rst)
    (go && pc_src == 2'b11) |=> pc_q == $past(alu_res));

  p_tload_r6: assert property (@(posedge clk) disable iff (rst)
    tgt_wr |=> tgt_q == $past(alu_res));

  p_thold_r6: assert property (@(posedge clk) disable iff (rst)
    !tgt_wr |=> $stable(tgt_q));

  p_condoff_r7: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && pc_wr_cond && !alu_zero) |=> $stable(pc_q));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && !pc_wr_cond) |=> $stable(pc_q));
endmodule

bind pcu_top pcu_chk #(.ADDR_W(ADDR_W), .JF_W(JF_W), .ALIGN(ALIGN)) u_chk (
  .clk (clk), .rst (rst), .alu_res (alu_res), .alu_zero (alu_zero),
  .jump_field (jump_field), .pc_wr (pc_wr), .pc_wr_cond (pc_wr_cond),
  .tgt_wr (tgt_wr), .pc_src (pc_src), .pc_q (pc_q), .tgt_q (tgt_q)
);

// File: tb/tb_pcu_top.sv
module tb_pcu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] alu_res = '0;
  logic        alu_zero = 1'b0;
  logic [25:0] jump_field = '0;
  logic        pc_wr = 1'b0, pc_wr_cond = 1'b0, tgt_wr = 1'b0;
  logic [1:0]  pc_src = 2'b00;
  logic [31:0] pc_q, tgt_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] m_pc = '0, m_tgt = '0, seed = 32'h1234_5678;

  always #10 clk = ~clk;   // 50 MHz

  pcu_top dut (
    .clk (clk), .rst (rst), .alu_res (alu_res), .alu_zero (alu_zero),
    .jump_field (jump_field), .pc_wr (pc_wr), .pc_wr_cond (pc_wr_cond),
    .tgt_wr (tgt_wr), .pc_src (pc_src), .pc_q (pc_q), .tgt_q (tgt_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // Apply one cycle of stimulus, update the model, check after the edge.
  task automatic cycle(input bit w, input bit wc, input bit z, input bit tw, input logic [1:0] s);
    logic [31:0] a, e_pc, e_tgt;
    logic [25:0] j;
    bit en;
    string req;
    a = rnd();
    j = rnd()[31:6];
    @(negedge clk);
    alu_res = a; jump_field = j; pc_wr = w; pc_wr_cond = wc;
    alu_zero = z; tgt_wr = tw; pc_src = s;
    en = w | (wc & z);
    if (!en) begin
      e_pc = m_pc;
      req = (wc && !z) ? "R7" : "R9";
    end else begin
      case (s)
        2'b01: begin e_pc = m_tgt; req = tw ? "R10" : "R3"; end
        2'b10: begin e_pc = {m_pc[31:28], j, 2'b00}; req = "R4"; end
        2'b11: begin e_pc = a; req = "R5"; end
        default: begin e_pc = a; req = "R2"; end
      endcase
      if (w && !z && !wc) req = {req, "/R8"};
    end
    e_tgt = tw ? a : m_tgt;
    @(posedge clk);
    #5;
    check(req, pc_q, e_pc);
    check(tw ? "R6 load" : "R6 hold", tgt_q, e_tgt);
    m_pc = e_pc;
    m_tgt = e_tgt;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    alu_res = 32'hDEAD_BEEF; tgt_wr = 1'b1; pc_wr = 1'b1;
    repeat (2) @(posedge clk);
    #5;
    check("R1 pc", pc_q, 32'h0);
    check("R1 tgt", tgt_q, 32'h0);
    @(negedge clk);
    rst = 1'b0; pc_wr = 1'b0; tgt_wr = 1'b0;

    // Seed PC with a known upper nibble, then jump (R4).
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 2'b10);

    for (int r = 0; r < 16; r++) begin
      for (int c = 0; c < 64; c++) begin
        cycle(c[0], c[1], c[2], c[3], c[5:4]);
      end
    end

    // R10 directed: load target and branch to old target together.
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 2'b00);
    cycle(1'b1, 1'b0, 1'b0, 1'b1, 2'b01);

    // Mid-run reset (R1).
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #5;
    check("R1 pc rerun", pc_q, 32'h0);
    check("R1 tgt rerun", tgt_q, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule